// File: doc/BRIEF.md
# Bus Interrupter with Qualified Event Status

This block gathers event conditions from a serial data-bus channel and records them in a 15-bit status register. It turns them into a priority-level interrupt request on a parallel backplane bus. A mask register decides which conditions may interrupt. A configuration register holds the 8-bit vector, the 3-bit request level, the status-update mode and the auto-clear option. When the bus master runs an interrupt-acknowledge cycle at the programmed level and the daisy-chain input reaches this block, the block answers with the vector and a data acknowledge, then withdraws its request.

Only one request is raised per service. Once the block has requested, later conditions are still recorded but cannot raise a new request. The host re-arms the block in one of two ways: it writes the interrupt-reset command, or it reads the status register while auto-clear is enabled. One status read returns every pending cause.

Top module: `vme_irq_ctrl`

## Requirements
- R1: After a synchronous reset, mask, configuration and status read as zero. No request line is asserted and no acknowledge is driven.
- R2: The host register map is as follows. Address 0 is the mask, bits 14..0, read and write. Address 1 is the status, read only, and writes to it are ignored. Address 2 is the configuration: vector in bits 7..0, level in bits 10..8, enhanced mode in bit 11, auto-clear in bit 12, all read and write. Address 3 is the command, write only, and reads as zero. Writes take effect at the clock edge that samples them.
- R3: In standard mode (bit 11 = 0), a condition sets its status bit only if its mask bit is 1.
- R4: In enhanced mode (bit 11 = 1), every condition sets its status bit whatever the mask holds.
- R5: A condition that passes the mask raises a request when the level is nonzero and the block is not blocked. The request appears as irq_o[level] from the cycle after the condition, and it is the only request bit high.
- R6: After a request is raised, the block stays blocked. Further masked-in conditions still latch but raise no new request until a clear.
- R7: Writing the command register with bit 0 set clears the status register and unblocks the block. A condition in the same cycle still latches and may raise a new request.
- R8: With auto-clear on, a read of the status register returns the current status, then clears it and unblocks the block.
- R9: With auto-clear off, reading the status register changes nothing.
- R10: When iack_i and iackin_i are high, a request is pending and iack_level_i equals the level, the block drives dtack_o high and the vector on vector_o in the same cycle. It holds iackout_o low, and it drops the request from the next cycle.
- R11: An acknowledge cycle that is not for this block passes iackin_i to iackout_i, drives no dtack_o and drives vector_o as zero.
- R12: A level of zero disables request generation. Status bits still latch as the mode dictates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 15 | Event conditions, one cycle pulse per occurrence |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | 2 | Host register select |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data for the selected register |
| irq_o | output | 7 | Request lines, indexed 7..1 by level |
| iack_i | input | 1 | Acknowledge cycle in progress |
| iack_level_i | input | 3 | Level being acknowledged |
| iackin_i | input | 1 | Daisy-chain acknowledge input |
| iackout_o | output | 1 | Daisy-chain acknowledge output |
| dtack_o | output | 1 | Data acknowledge for this block's vector |
| vector_o | output | 8 | Vector on data bits 7..0 |

## Verification
The main risk is the blocking flag. If it stays set after a clear, the block goes silent forever, and the next masked-in event shows no request at the following cycle. If it clears too early, a second request appears one cycle after a condition that should have been absorbed. A wrong mode or mask on the status path shows up at the next status read as an extra or missing bit. A wrong acknowledge match shows up in the same cycle, as dtack_o and iackout_o both wrong. Comparing every port on every cycle against an independent model catches each of these faults within one or two cycles of its cause.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NUM_COND = 15;
    localparam int VEC_W    = 8;
    localparam int LVL_W    = 3;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int NUM_LVL  = (1 << LVL_W) - 1;
    localparam int CMD_IRST_BIT = 0;

    // condition slots used by the channel
    localparam int COND_MSG_DONE   = 0;
    localparam int COND_LIST_DONE  = 1;
    localparam int COND_MSG_ERR    = 2;
    localparam int COND_TAG_WRAP   = 3;
    localparam int COND_RETRY      = 4;
    localparam int COND_DSTK_WRAP  = 5;
    localparam int COND_CSTK_WRAP  = 6;
    localparam int COND_TX_TIMEOUT = 7;
    localparam int COND_MEM_PARITY = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_CMD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             autoclr;
        logic             enhanced;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } irq_cfg_t;

    localparam int CFG_W = $bits(irq_cfg_t);

    function automatic logic level_on(input logic [LVL_W-1:0] l);
        return l != '0;
    endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int N = NUM_COND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N-1:0]      mask_o,
    output irq_cfg_t          cfg_o,
    output logic              clr_o
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o <= '0;
            cfg_o  <= '0;
        end else if (wr_i) begin
            if (sel == SEL_MASK) mask_o <= wdata_i[N-1:0];
            if (sel == SEL_CFG)  cfg_o  <= irq_cfg_t'(wdata_i[CFG_W-1:0]);
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_MASK: rdata_o[N-1:0]     = mask_o;
            SEL_STAT: rdata_o[N-1:0]     = status_i;
            SEL_CFG:  rdata_o[CFG_W-1:0] = cfg_o;
            default:  rdata_o = '0;
        endcase
    end

    assign clr_o = (wr_i && sel == SEL_CMD && wdata_i[CMD_IRST_BIT]) ||
                   (rd_i && sel == SEL_STAT && cfg_o.autoclr);

    // R2: status never changes the mask
    a_r2_mask_stable: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && sel == SEL_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/irqv_status.sv
module irqv_status
    import irqv_pkg::*;
#(
    parameter int N = NUM_COND
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] mask_i,
    input  logic         enhanced_i,
    input  logic         clr_i,
    output logic [N-1:0] status_o,
    output logic         qual_any_o
);
    logic [N-1:0] qual, setv;

    assign qual       = cond_i & mask_i;
    assign setv       = enhanced_i ? cond_i : qual;
    assign qual_any_o = |qual;

    always_ff @(posedge clk) begin
        if (rst) status_o <= '0;
        else     status_o <= (clr_i ? '0 : status_o) | setv;
    end

    // R3: standard mode adds only masked-in bits
    a_r3_std_masked: assert property (@(posedge clk) disable iff (rst)
        !enhanced_i |=> ((status_o & ~$past(status_o) & ~$past(mask_i)) == '0));
    // R4: enhanced mode records every condition
    a_r4_enh_all: assert property (@(posedge clk) disable iff (rst)
        enhanced_i |=> (($past(cond_i) & ~status_o) == '0));
endmodule

// File: rtl/irqv_req.sv
module irqv_req (
    input  logic clk,
    input  logic rst,
    input  logic qual_any_i,
    input  logic level_on_i,
    input  logic clr_i,
    input  logic ack_i,
    output logic req_o
);
    logic blk_q, fire;

    assign fire = qual_any_i && level_on_i && (!blk_q || clr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= 1'b0;
            req_o <= 1'b0;
        end else begin
            blk_q <= fire || (blk_q && !clr_i);
            req_o <= fire || (req_o && !ack_i);
        end
    end

    // R6: while blocked and not cleared, no fresh request
    a_r6_no_rerequest: assert property (@(posedge clk) disable iff (rst)
        (blk_q && !clr_i) |=> !$rose(req_o));
    // R10: an acknowledge removes the request
    a_r10_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !fire) |=> !req_o);
    // R5: a new request always leaves the block blocked
    a_r5_blocks: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> blk_q);
endmodule

// File: rtl/irqv_iack.sv
module irqv_iack
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  irq_cfg_t         cfg_i,
    input  logic             iack_i,
    input  logic [LVL_W-1:0] iack_level_i,
    input  logic             iackin_i,
    output logic [NUM_LVL:1] irq_o,
    output logic             iackout_o,
    output logic             dtack_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             ack_o
);
    logic hit;

    assign hit       = iack_i && iackin_i && req_i && level_on(cfg_i.level) &&
                       (iack_level_i == cfg_i.level);
    assign ack_o     = hit;
    assign dtack_o   = hit;
    assign vector_o  = hit ? cfg_i.vector : '0;
    assign iackout_o = iack_i && iackin_i && !hit;

    for (genvar k = 1; k <= NUM_LVL; k++) begin : g_line
        assign irq_o[k] = req_i && (cfg_i.level == LVL_W'(k));
    end

    // R5: at most one request line
    a_r5_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(irq_o));
    // R11: acknowledge is either taken or passed, never both
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dtack_o && iackout_o));
    // R12: level zero raises no line
    a_r12_level_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.level == '0) |-> (irq_o == '0));
endmodule

// File: rtl/vme_irq_ctrl.sv
module vme_irq_ctrl
    import irqv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic                host_wr_i,
    input  logic                host_rd_i,
    input  logic [ADDR_W-1:0]   host_addr_i,
    input  logic [DATA_W-1:0]   host_wdata_i,
    output logic [DATA_W-1:0]   host_rdata_o,
    output logic [NUM_LVL:1]    irq_o,
    input  logic                iack_i,
    input  logic [LVL_W-1:0]    iack_level_i,
    input  logic                iackin_i,
    output logic                iackout_o,
    output logic                dtack_o,
    output logic [VEC_W-1:0]    vector_o
);
    logic [NUM_COND-1:0] mask, status;
    irq_cfg_t            cfg;
    logic                clr, qual_any, req, ack;

    irqv_regs #(.N(NUM_COND)) i_regs (
        .clk(clk), .rst(rst), .wr_i(host_wr_i), .rd_i(host_rd_i),
        .addr_i(host_addr_i), .wdata_i(host_wdata_i), .status_i(status),
        .rdata_o(host_rdata_o), .mask_o(mask), .cfg_o(cfg), .clr_o(clr)
    );

    irqv_status #(.N(NUM_COND)) i_status (
        .clk(clk), .rst(rst), .cond_i(cond_i), .mask_i(mask),
        .enhanced_i(cfg.enhanced), .clr_i(clr),
        .status_o(status), .qual_any_o(qual_any)
    );

    irqv_req i_req (
        .clk(clk), .rst(rst), .qual_any_i(qual_any),
        .level_on_i(level_on(cfg.level)), .clr_i(clr), .ack_i(ack),
        .req_o(req)
    );

    irqv_iack i_iack (
        .clk(clk), .rst(rst), .req_i(req), .cfg_i(cfg), .iack_i(iack_i),
        .iack_level_i(iack_level_i), .iackin_i(iackin_i), .irq_o(irq_o),
        .iackout_o(iackout_o), .dtack_o(dtack_o), .vector_o(vector_o),
        .ack_o(ack)
    );
endmodule

// File: tb/test_vme_irq_ctrl.sv
module test_vme_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] cond = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:1]  irq;
    logic        iack = 1'b0, iackin = 1'b0;
    logic [2:0]  iack_lvl = '0;
    logic        iackout, dtack;
    logic [7:0]  vec;

    always #5 clk = ~clk;

    vme_irq_ctrl i_vme_irq_ctrl (
        .clk(clk), .rst(rst), .cond_i(cond), .host_wr_i(wr), .host_rd_i(rd),
        .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
        .irq_o(irq), .iack_i(iack), .iack_level_i(iack_lvl), .iackin_i(iackin),
        .iackout_o(iackout), .dtack_o(dtack), .vector_o(vec)
    );

    int    n_vec = 0, n_bad = 0;
    string tag = "R1";

    // behavioural reference state
    int m_mask = 0, m_stat = 0, m_vec = 0, m_lvl = 0;
    bit m_enh = 0, m_acl = 0, m_req = 0, m_blk = 0;

    function automatic bit m_hit();
        return iack && iackin && m_req && m_lvl != 0 && int'(iack_lvl) == m_lvl;
    endfunction

    task automatic compare();
        int e_irq, e_rd;
        bit h;
        h = m_hit();
        e_irq = (m_req && m_lvl != 0) ? (1 << m_lvl) : 0;
        case (addr)
            2'd0: e_rd = m_mask;
            2'd1: e_rd = m_stat;
            2'd2: e_rd = (int'(m_acl) << 12) | (int'(m_enh) << 11) | (m_lvl << 8) | m_vec;
            default: e_rd = 0;
        endcase
        n_vec++;
        if ({irq, 1'b0} !== 8'(e_irq) || dtack !== h || iackout !== (iack && iackin && !h) ||
            vec !== (h ? 8'(m_vec) : 8'h00) || rdata !== 16'(e_rd)) begin
            n_bad++;
            $display("FAIL %s t=%0t irq=%b/%b dtack=%b/%b iackout=%b/%b vec=%h/%h rdata=%h/%h",
                     tag, $time, {irq, 1'b0}, 8'(e_irq), dtack, h, iackout,
                     (iack && iackin && !h), vec, (h ? 8'(m_vec) : 8'h00), rdata, 16'(e_rd));
        end
    endtask

    task automatic model_update();
        int qual, setv;
        bit clr, fire, h;
        if (rst) begin
            m_mask = 0; m_stat = 0; m_vec = 0; m_lvl = 0;
            m_enh = 0; m_acl = 0; m_req = 0; m_blk = 0;
            return;
        end
        h    = m_hit();
        qual = int'(cond) & m_mask;
        setv = m_enh ? int'(cond) : qual;
        clr  = (wr && addr == 2'd3 && wdata[0]) || (rd && addr == 2'd1 && m_acl);
        fire = qual != 0 && m_lvl != 0 && (!m_blk || clr);
        m_stat = (clr ? 0 : m_stat) | setv;
        m_blk  = fire || (m_blk && !clr);
        m_req  = fire || (m_req && !h);
        if (wr && addr == 2'd0) m_mask = int'(wdata[14:0]);
        if (wr && addr == 2'd2) begin
            m_vec = int'(wdata[7:0]); m_lvl = int'(wdata[10:8]);
            m_enh = wdata[11]; m_acl = wdata[12];
        end
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d; step(); wr = 1'b0; wdata = '0;
    endtask

    task automatic hread(input logic [1:0] a);
        rd = 1'b1; addr = a; step(); rd = 1'b0;
    endtask

    task automatic pulse(input logic [14:0] c);
        cond = c; step(); cond = '0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        @(posedge clk); @(posedge clk);
        model_update();
        @(negedge clk);
        idle(1);
        rst = 1'b0;
        tag = "R1"; hread(2'd0); hread(2'd1); hread(2'd2); hread(2'd3);

        tag = "R2";
        hwrite(2'd0, 16'h8003); hread(2'd0);
        hwrite(2'd2, 16'hE3A5); hread(2'd2);
        hwrite(2'd1, 16'h7FFF); hread(2'd1);
        hread(2'd3);
        hwrite(2'd2, 16'h03A5);

        tag = "R3"; pulse(15'h0106); hread(2'd1);
        tag = "R5"; pulse(15'h0001); idle(2);
        tag = "R6"; pulse(15'h0002); idle(1); hread(2'd1);

        tag = "R11"; iack = 1; iackin = 1; iack_lvl = 3'd5; step();
        iackin = 0; iack_lvl = 3'd3; step();
        tag = "R10"; iackin = 1; step(); iack = 0; iackin = 0; idle(2);

        tag = "R9"; hread(2'd1); hread(2'd1); pulse(15'h0001); idle(1);
        tag = "R7"; hwrite(2'd3, 16'h0001); hread(2'd1); pulse(15'h0002); idle(1);
        cond = 15'h0001; hwrite(2'd3, 16'h0001); cond = '0; hread(2'd1);
        iack = 1; iackin = 1; iack_lvl = 3'd3; step(); iack = 0; iackin = 0;

        tag = "R4"; hwrite(2'd2, 16'h1E42); hwrite(2'd0, 16'h0010);
        hwrite(2'd3, 16'h0001); pulse(15'h4108); hread(2'd0); addr = 2'd1; step();
        pulse(15'h0010); idle(1);
        tag = "R8"; hread(2'd1); hread(2'd1); pulse(15'h0030); idle(1);
        iack = 1; iackin = 1; iack_lvl = 3'd6; step(); iack = 0; iackin = 0; idle(1);

        tag = "R12"; hwrite(2'd2, 16'h0042); hwrite(2'd3, 16'h0001);
        hwrite(2'd0, 16'h7FFF); pulse(15'h0011); idle(2); hread(2'd1);
        iack = 1; iackin = 1; iack_lvl = 3'd0; step(); iack = 0; iackin = 0;
        hwrite(2'd2, 16'h0742); pulse(15'h0004); idle(1);
        iack = 1; iackin = 1; iack_lvl = 3'd7; step(); iack = 0; iackin = 0;

        tag = "R1"; rst = 1'b1; step(); rst = 1'b0; hread(2'd1); hread(2'd2); idle(2);

        summary();
        $finish;
    end
endmodule